// File: doc/BRIEF.md
# Multi-queue Ethernet DMA control and status registers

This block is the register file that software uses to steer a multi-queue Ethernet DMA engine. It decodes 32-bit word accesses in a 4 KB window. It holds interrupt events and their mask, and it drives three interrupt lines: transmit, receive and error. It also keeps a halt flag for each transmit and each receive queue, a base and a live descriptor pointer for each ring, and a DMA control word. That control word carries the graceful-stop requests and the polling enable.

The descriptor engines get their instructions through one-cycle restart strobes, one per queue. Software clears a halt flag to restart its ring. Writing a ring base also reloads that ring's live pointer. A graceful stop finishes at once when the engine is idle. When a frame is in flight, the stop completes only after that frame ends. While polling is enabled, a timer restarts transmit queue 0 once per period, unless a transmit stop is pending.

Top module: `eth_dma_csr`

Word map (byte offsets): event 0x000, mask 0x004, DMA control 0x008, transmit halt 0x00C, receive halt 0x010, event force 0x014, identity 0x018. Ring registers use queue q: transmit base 0x100+4q, receive base 0x120+4q, transmit pointer 0x140+4q, receive pointer 0x160+4q.

## Requirements
- R1: After reset every register reads zero, all three interrupt outputs are low and no restart strobe is asserted.
- R2: Only accesses with addr_i[1:0]==0 take effect. The event-force register (0x014) is write-only and reads zero. The identity register (0x018) reads HW_ID and ignores writes. Unmapped offsets read zero and ignore writes.
- R3: The event register is write-1-to-clear. Writing 0x014 sets the event bits where the data is 1. A hardware set (evt_set_i or a stop-complete) in the same cycle as a clear wins.
- R4: tx_irq_o is the OR of (event AND mask) bits 7:0, rx_irq_o is the OR over bits 15:8, and err_irq_o is the OR over bits 31:16. Each is valid in the cycle after the register write that changes it.
- R5: Transmit halt flag for queue i is bit 31-i of 0x00C. Writing 1 there clears it and pulses tx_restart_o[i] for one cycle, starting in the cycle after the write, whether or not the flag was set.
- R6: Receive halt flag for queue i is bit 23-i of 0x010. Writing 1 clears it, and rx_restart_o[i] pulses only when that flag was already clear before the write.
- R7: Writing a ring base stores the data with bits 2:0 forced to zero and loads the same value into that ring's pointer register, which also appears on the pointer output.
- R8: A pointer register can be written directly (bits 2:0 forced to zero) without changing its base.
- R9: DMA control bit 0 requests a receive stop, bit 1 a transmit stop, bit 2 is wait-on-poll. Writing bit 0 with rx_busy_i low sets event bit 9 at once. Writing bit 1 with tx_busy_i low sets event bit 1 at once.
- R10: If the engine is busy when the stop is written, the stop-complete event stays clear while it is busy. The event is set in the cycle after the busy input falls, provided the stop bit is still set.
- R11: While wait-on-poll is 0, tx_restart_o[0] pulses every POLL_CYCLES cycles. A DMA control write with wait-on-poll 0 restarts the period, so the first pulse is seen POLL_CYCLES cycles after the write. No pulse occurs while wait-on-poll is 1 or a transmit stop is requested.
- R12: tx_halt_set_i[i] and rx_halt_set_i[i] set the halt flags. A set in the same cycle as a software clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write when high, read otherwise |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| tx_irq_o | output | 1 | Transmit group interrupt |
| rx_irq_o | output | 1 | Receive group interrupt |
| err_irq_o | output | 1 | Error group interrupt |
| evt_set_i | input | 32 | Hardware event set pulses |
| tx_halt_set_i | input | NQ | Transmit queue halted pulses |
| rx_halt_set_i | input | NQ | Receive queue halted pulses |
| tx_busy_i | input | 1 | Transmit frame in progress |
| rx_busy_i | input | 1 | Receive frame in progress |
| tx_restart_o | output | NQ | Transmit ring restart strobes |
| rx_restart_o | output | NQ | Receive ring restart strobes |
| tx_stop_o | output | 1 | Graceful transmit stop requested |
| rx_stop_o | output | 1 | Graceful receive stop requested |
| tx_base_o | output | NQ*32 | Transmit ring bases, queue q at [32q+:32] |
| rx_base_o | output | NQ*32 | Receive ring bases |
| tx_ptr_o | output | NQ*32 | Transmit live pointers |
| rx_ptr_o | output | NQ*32 | Receive live pointers |

## Verification
The properties assume that the engines drive the busy inputs as clean levels. They also assume the halt-set and event-set inputs are single-cycle pulses and that a bus write is held for exactly one clock. The bench changes every input on the falling edge. It raises a busy input before the stop is written and drops it only after the stop has been seen pending. It disables polling around every test except the one for the polling timer, so that queue-0 strobes in the other tests come only from halt writes.

// File: rtl/eth_csr_pkg.sv
package eth_csr_pkg;
  localparam int unsigned IDX_W = 10;

  localparam logic [IDX_W-1:0] IX_EVT = 10'h000;
  localparam logic [IDX_W-1:0] IX_MSK = 10'h001;
  localparam logic [IDX_W-1:0] IX_DMA = 10'h002;
  localparam logic [IDX_W-1:0] IX_TXH = 10'h003;
  localparam logic [IDX_W-1:0] IX_RXH = 10'h004;
  localparam logic [IDX_W-1:0] IX_EVF = 10'h005;
  localparam logic [IDX_W-1:0] IX_ID  = 10'h006;
  localparam logic [IDX_W-1:0] IX_TXB = 10'h040;
  localparam logic [IDX_W-1:0] IX_RXB = 10'h048;
  localparam logic [IDX_W-1:0] IX_TXP = 10'h050;
  localparam logic [IDX_W-1:0] IX_RXP = 10'h058;

  localparam int unsigned EVT_GTSC = 1;
  localparam int unsigned EVT_GRSC = 9;

  localparam logic [31:0] GRP_TX  = 32'h0000_00FF;
  localparam logic [31:0] GRP_RX  = 32'h0000_FF00;
  localparam logic [31:0] GRP_ERR = 32'hFFFF_0000;

  localparam logic [31:0] ALIGN_MASK = 32'hFFFF_FFF8;

  // bit 2 wop, bit 1 gts, bit 0 grs
  typedef struct packed {
    logic wop;
    logic gts;
    logic grs;
  } dma_ctl_t;
endpackage

// File: rtl/eth_csr_irq.sv
module eth_csr_irq
  import eth_csr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        evt_clr_i,
  input  logic        msk_wr_i,
  input  logic        frc_wr_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] hw_set_i,
  output logic [31:0] evt_o,
  output logic [31:0] msk_o,
  output logic        tx_irq_o,
  output logic        rx_irq_o,
  output logic        err_irq_o
);
  logic [31:0] evt_q, msk_q, clr_bits, frc_bits, active;

  assign clr_bits = evt_clr_i ? wdata_i : '0;
  assign frc_bits = frc_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= '0;
      msk_q <= '0;
    end else begin
      evt_q <= (evt_q & ~clr_bits) | hw_set_i | frc_bits;
      if (msk_wr_i) msk_q <= wdata_i;
    end
  end

  assign active    = evt_q & msk_q;
  assign tx_irq_o  = |(active & GRP_TX);
  assign rx_irq_o  = |(active & GRP_RX);
  assign err_irq_o = |(active & GRP_ERR);
  assign evt_o     = evt_q;
  assign msk_o     = msk_q;
endmodule

// File: rtl/eth_csr_halt.sv
module eth_csr_halt #(
  parameter int unsigned NQ = 8,
  parameter bit GATE_ON_CLEAR = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [NQ-1:0] wbits_i,
  input  logic [NQ-1:0] set_i,
  input  logic [NQ-1:0] kick_i,
  output logic [NQ-1:0] halt_o,
  output logic [NQ-1:0] restart_o
);
  logic [NQ-1:0] halt_q, restart_q, clr, hit;

  assign clr = wr_i ? wbits_i : '0;

  generate
    if (GATE_ON_CLEAR) begin : g_gated
      assign hit = clr & ~halt_q;
    end else begin : g_plain
      assign hit = clr;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q    <= '0;
      restart_q <= '0;
    end else begin
      halt_q    <= (halt_q & ~clr) | set_i;
      restart_q <= hit | kick_i;
    end
  end

  assign halt_o    = halt_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/eth_csr_ring.sv
module eth_csr_ring
  import eth_csr_pkg::*;
#(
  parameter int unsigned NQ = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NQ-1:0]        base_we_i,
  input  logic [NQ-1:0]        ptr_we_i,
  input  logic [31:0]          wdata_i,
  output logic [NQ-1:0][31:0]  base_o,
  output logic [NQ-1:0][31:0]  ptr_o
);
  logic [31:0] aligned;
  assign aligned = wdata_i & ALIGN_MASK;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[q] <= '0;
        ptr_o[q]  <= '0;
      end else if (base_we_i[q]) begin
        base_o[q] <= aligned;
        ptr_o[q]  <= aligned;
      end else if (ptr_we_i[q]) begin
        ptr_o[q]  <= aligned;
      end
    end
  end
endmodule

// File: rtl/eth_csr_dma.sv
module eth_csr_dma
  import eth_csr_pkg::*;
#(
  parameter int unsigned POLL_CYCLES = 1000
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  logic [2:0] wdata_i,
  input  logic     tx_busy_i,
  input  logic     rx_busy_i,
  output dma_ctl_t ctl_o,
  output logic     gtsc_o,
  output logic     grsc_o,
  output logic     poll_kick_o
);
  localparam int unsigned CW = $clog2(POLL_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(POLL_CYCLES - 1);

  dma_ctl_t ctl_q, wctl;
  logic tx_busy_q, rx_busy_q, tick;
  logic [CW-1:0] cnt_q;

  assign wctl = dma_ctl_t'(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q     <= '0;
      tx_busy_q <= 1'b0;
      rx_busy_q <= 1'b0;
      cnt_q     <= RELOAD;
    end else begin
      tx_busy_q <= tx_busy_i;
      rx_busy_q <= rx_busy_i;
      if (wr_i) ctl_q <= wctl;
      if (wr_i && !wctl.wop)   cnt_q <= RELOAD;
      else if (!ctl_q.wop)     cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
    end
  end

  assign tick        = !ctl_q.wop && (cnt_q == '0);
  assign poll_kick_o = tick && !ctl_q.gts;

  // immediate completion on write, or deferred to the busy falling edge
  assign gtsc_o = (wr_i && wctl.gts && !tx_busy_i) ||
                  (ctl_q.gts && tx_busy_q && !tx_busy_i);
  assign grsc_o = (wr_i && wctl.grs && !rx_busy_i) ||
                  (ctl_q.grs && rx_busy_q && !rx_busy_i);
  assign ctl_o  = ctl_q;
endmodule

// File: rtl/eth_dma_csr.sv
module eth_dma_csr
  import eth_csr_pkg::*;
#(
  parameter int unsigned NQ          = 8,
  parameter int unsigned POLL_CYCLES = 1000,
  parameter logic [31:0] HW_ID       = 32'h0E7C_0001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [11:0]      addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             tx_irq_o,
  output logic             rx_irq_o,
  output logic             err_irq_o,
  input  logic [31:0]      evt_set_i,
  input  logic [NQ-1:0]    tx_halt_set_i,
  input  logic [NQ-1:0]    rx_halt_set_i,
  input  logic             tx_busy_i,
  input  logic             rx_busy_i,
  output logic [NQ-1:0]    tx_restart_o,
  output logic [NQ-1:0]    rx_restart_o,
  output logic             tx_stop_o,
  output logic             rx_stop_o,
  output logic [NQ*32-1:0] tx_base_o,
  output logic [NQ*32-1:0] rx_base_o,
  output logic [NQ*32-1:0] tx_ptr_o,
  output logic [NQ*32-1:0] rx_ptr_o
);
  logic             acc_ok, wr;
  logic [IDX_W-1:0] ix;
  logic [31:0]      evt_q, msk_q, hw_set;
  dma_ctl_t         ctl_q;
  logic             gtsc, grsc, poll_kick;
  logic [NQ-1:0]    tx_wbits, rx_wbits, tx_halt_q, rx_halt_q, tx_kick;
  logic [NQ-1:0]    txb_we, rxb_we, txp_we, rxp_we;
  logic [NQ-1:0][31:0] txb, rxb, txp, rxp;

  assign acc_ok = req_i && (addr_i[1:0] == 2'b00);
  assign wr     = acc_ok && we_i;
  assign ix     = addr_i[11:2];

  for (genvar q = 0; q < NQ; q++) begin : g_map
    assign tx_wbits[q] = wdata_i[31-q];
    assign rx_wbits[q] = wdata_i[23-q];
    assign txb_we[q]   = wr && (ix == IX_TXB + IDX_W'(q));
    assign rxb_we[q]   = wr && (ix == IX_RXB + IDX_W'(q));
    assign txp_we[q]   = wr && (ix == IX_TXP + IDX_W'(q));
    assign rxp_we[q]   = wr && (ix == IX_RXP + IDX_W'(q));
  end

  assign hw_set = evt_set_i | (32'(gtsc) << EVT_GTSC) | (32'(grsc) << EVT_GRSC);
  assign tx_kick = NQ'(poll_kick);

  eth_csr_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_clr_i (wr && ix == IX_EVT),
    .msk_wr_i  (wr && ix == IX_MSK),
    .frc_wr_i  (wr && ix == IX_EVF),
    .wdata_i   (wdata_i),
    .hw_set_i  (hw_set),
    .evt_o     (evt_q),
    .msk_o     (msk_q),
    .tx_irq_o  (tx_irq_o),
    .rx_irq_o  (rx_irq_o),
    .err_irq_o (err_irq_o)
  );

  eth_csr_halt #(.NQ(NQ), .GATE_ON_CLEAR(1'b0)) u_txh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr && ix == IX_TXH),
    .wbits_i   (tx_wbits),
    .set_i     (tx_halt_set_i),
    .kick_i    (tx_kick),
    .halt_o    (tx_halt_q),
    .restart_o (tx_restart_o)
  );

  eth_csr_halt #(.NQ(NQ), .GATE_ON_CLEAR(1'b1)) u_rxh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr && ix == IX_RXH),
    .wbits_i   (rx_wbits),
    .set_i     (rx_halt_set_i),
    .kick_i    ('0),
    .halt_o    (rx_halt_q),
    .restart_o (rx_restart_o)
  );

  eth_csr_ring #(.NQ(NQ)) u_txr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_we_i (txb_we),
    .ptr_we_i  (txp_we),
    .wdata_i   (wdata_i),
    .base_o    (txb),
    .ptr_o     (txp)
  );

  eth_csr_ring #(.NQ(NQ)) u_rxr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_we_i (rxb_we),
    .ptr_we_i  (rxp_we),
    .wdata_i   (wdata_i),
    .base_o    (rxb),
    .ptr_o     (rxp)
  );

  eth_csr_dma #(.POLL_CYCLES(POLL_CYCLES)) u_dma (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr && ix == IX_DMA),
    .wdata_i     (wdata_i[2:0]),
    .tx_busy_i   (tx_busy_i),
    .rx_busy_i   (rx_busy_i),
    .ctl_o       (ctl_q),
    .gtsc_o      (gtsc),
    .grsc_o      (grsc),
    .poll_kick_o (poll_kick)
  );

  assign tx_stop_o = ctl_q.gts;
  assign rx_stop_o = ctl_q.grs;
  assign tx_base_o = txb;
  assign rx_base_o = rxb;
  assign tx_ptr_o  = txp;
  assign rx_ptr_o  = rxp;

  always_comb begin
    rdata_o = '0;
    if (addr_i[1:0] == 2'b00) begin
      unique case (ix)
        IX_EVT: rdata_o = evt_q;
        IX_MSK: rdata_o = msk_q;
        IX_DMA: rdata_o = 32'(ctl_q);
        IX_ID:  rdata_o = HW_ID;
        IX_TXH: for (int q = 0; q < NQ; q++) rdata_o[31-q] = tx_halt_q[q];
        IX_RXH: for (int q = 0; q < NQ; q++) rdata_o[23-q] = rx_halt_q[q];
        default: begin
          for (int q = 0; q < NQ; q++) begin
            if (ix == IX_TXB + IDX_W'(q)) rdata_o = txb[q];
            if (ix == IX_RXB + IDX_W'(q)) rdata_o = rxb[q];
            if (ix == IX_TXP + IDX_W'(q)) rdata_o = txp[q];
            if (ix == IX_RXP + IDX_W'(q)) rdata_o = rxp[q];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eth_dma_csr_chk.sv
module eth_dma_csr_chk
  import eth_csr_pkg::*;
#(
  parameter int unsigned NQ = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [11:0]      addr_i,
  input logic [31:0]      wdata_i,
  input logic             tx_irq_o,
  input logic             rx_irq_o,
  input logic             err_irq_o,
  input logic [31:0]      msk_q,
  input logic [31:0]      evt_q,
  input dma_ctl_t         ctl_q,
  input logic [NQ-1:0]    rx_halt_q,
  input logic [NQ-1:0]    tx_restart_o,
  input logic [NQ-1:0]    rx_restart_o,
  input logic [NQ*32-1:0] tx_ptr_o,
  input logic             rx_busy_i
);
  logic wr_ok;
  logic [IDX_W-1:0] ix;
  assign wr_ok = req_i && we_i && (addr_i[1:0] == 2'b00);
  assign ix    = addr_i[11:2];

  a_r4_mask_zero_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_q == '0) |-> !(tx_irq_o || rx_irq_o || err_irq_o));

  a_r5_tx_clear_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && ix == IX_TXH && wdata_i[31]) |=> tx_restart_o[0]);

  a_r6_rx_set_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && ix == IX_RXH && wdata_i[23] && rx_halt_q[0]) |=> !rx_restart_o[0]);

  a_r7_base_loads_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && ix == IX_TXB) |=> (tx_ptr_o[31:0] == ($past(wdata_i) & ALIGN_MASK)));

  a_r9_grs_idle_now: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && ix == IX_DMA && wdata_i[0] && !rx_busy_i) |=> evt_q[EVT_GRSC]);

  a_r11_gts_blocks_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.gts && !(wr_ok && ix == IX_TXH && wdata_i[31])) |=> !tx_restart_o[0]);
endmodule

bind eth_dma_csr eth_dma_csr_chk #(.NQ(NQ)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .tx_irq_o     (tx_irq_o),
  .rx_irq_o     (rx_irq_o),
  .err_irq_o    (err_irq_o),
  .msk_q        (msk_q),
  .evt_q        (evt_q),
  .ctl_q        (ctl_q),
  .rx_halt_q    (rx_halt_q),
  .tx_restart_o (tx_restart_o),
  .rx_restart_o (rx_restart_o),
  .tx_ptr_o     (tx_ptr_o),
  .rx_busy_i    (rx_busy_i)
);

// File: tb/sim_eth_dma_csr.sv
`timescale 1ns/1ps
module sim_eth_dma_csr;
  localparam int NQ = 8;
  localparam int P  = 40;
  localparam logic [31:0] ID = 32'h0E7C_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, evt_set = '0;
  logic tx_irq, rx_irq, err_irq, tx_busy = 1'b0, rx_busy = 1'b0, tx_stop, rx_stop;
  logic [NQ-1:0] txh_set = '0, rxh_set = '0, tx_rs, rx_rs;
  logic [NQ*32-1:0] tx_base, rx_base, tx_ptr, rx_ptr;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  eth_dma_csr #(.NQ(NQ), .POLL_CYCLES(P), .HW_ID(ID)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq),
    .err_irq_o(err_irq), .evt_set_i(evt_set), .tx_halt_set_i(txh_set),
    .rx_halt_set_i(rxh_set), .tx_busy_i(tx_busy), .rx_busy_i(rx_busy),
    .tx_restart_o(tx_rs), .rx_restart_o(rx_rs), .tx_stop_o(tx_stop),
    .rx_stop_o(rx_stop), .tx_base_o(tx_base), .rx_base_o(rx_base),
    .tx_ptr_o(tx_ptr), .rx_ptr_o(rx_ptr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irqs", {29'd0, tx_irq, rx_irq, err_irq}, 32'd0);
    chk("R1 strobes", {16'd0, tx_rs, rx_rs}, 32'd0);
    rd(12'h000, v); chk("R1 evt", v, 0);
    rd(12'h004, v); chk("R1 msk", v, 0);
    rd(12'h008, v); chk("R1 dma", v, 0);
    rd(12'h00C, v); chk("R1 txh", v, 0);
    rd(12'h104, v); chk("R1 txbase", v, 0);
    wr(12'h008, 32'h4);
  endtask

  task automatic t_access();
    logic [31:0] v;
    rd(12'h018, v); chk("R2 id", v, ID);
    wr(12'h018, 32'h1234_5678);
    rd(12'h018, v); chk("R2 id ro", v, ID);
    wr(12'h0FC, 32'hFFFF_FFFF);
    rd(12'h0FC, v); chk("R2 unmapped", v, 0);
    wr(12'h014, 32'h0000_0000);
    rd(12'h014, v); chk("R2 wo reads 0", v, 0);
    wr(12'h006, 32'hFFFF_FFFF);
    rd(12'h004, v); chk("R2 misaligned ignored", v, 0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    wr(12'h014, 32'h0001_0201);
    rd(12'h000, v); chk("R3 force", v, 32'h0001_0201);
    chk("R4 masked off", {29'd0, tx_irq, rx_irq, err_irq}, 0);
    wr(12'h004, 32'h0000_0001);
    chk("R4 tx only", {29'd0, tx_irq, rx_irq, err_irq}, 32'b100);
    wr(12'h004, 32'hFFFF_FFFF);
    chk("R4 all", {29'd0, tx_irq, rx_irq, err_irq}, 32'b111);
    wr(12'h000, 32'h0000_0200);
    rd(12'h000, v); chk("R3 w1c", v, 32'h0001_0001);
    chk("R4 rx dropped", {29'd0, tx_irq, rx_irq, err_irq}, 32'b101);
    evt_set = 32'h0000_0001;
    wr(12'h000, 32'h0000_0001);
    evt_set = '0;
    rd(12'h000, v); chk("R3 set wins", v, 32'h0001_0001);
    wr(12'h000, 32'hFFFF_FFFF);
    chk("R4 cleared", {29'd0, tx_irq, rx_irq, err_irq}, 0);
    wr(12'h004, 32'h0);
  endtask

  task automatic t_tx_halt();
    logic [31:0] v;
    txh_set = 8'b0000_0101; step(); txh_set = '0;
    rd(12'h00C, v); chk("R12 tx set", v, 32'hA000_0000);
    wr(12'h00C, 32'h8000_0000);
    chk("R5 strobe q0", {24'd0, tx_rs}, 32'h01);
    rd(12'h00C, v); chk("R5 cleared", v, 32'h2000_0000);
    step();
    chk("R5 one cycle", {24'd0, tx_rs}, 0);
    wr(12'h00C, 32'h4000_0000);
    chk("R5 strobe clear q1", {24'd0, tx_rs}, 32'h02);
    txh_set = 8'b0000_0100;
    wr(12'h00C, 32'h2000_0000);
    txh_set = '0;
    rd(12'h00C, v); chk("R12 set wins", v, 32'h2000_0000);
  endtask

  task automatic t_rx_halt();
    logic [31:0] v;
    rxh_set = 8'b0000_1001; step(); rxh_set = '0;
    rd(12'h010, v); chk("R12 rx set", v, 32'h0090_0000);
    wr(12'h010, 32'h0080_0000);
    chk("R6 no strobe halted", {24'd0, rx_rs}, 0);
    rd(12'h010, v); chk("R6 cleared", v, 32'h0010_0000);
    wr(12'h010, 32'h0040_0000);
    chk("R6 strobe clear q1", {24'd0, rx_rs}, 32'h02);
  endtask

  task automatic t_ring();
    logic [31:0] v;
    wr(12'h10C, 32'h1234_567F);
    rd(12'h10C, v); chk("R7 base align", v, 32'h1234_5678);
    rd(12'h14C, v); chk("R7 ptr loaded", v, 32'h1234_5678);
    chk("R7 ptr port", tx_ptr[3*32 +: 32], 32'h1234_5678);
    wr(12'h13C, 32'hFFFF_FFFF);
    rd(12'h17C, v); chk("R7 rx ptr", v, 32'hFFFF_FFF8);
    chk("R7 rx base port", rx_base[7*32 +: 32], 32'hFFFF_FFF8);
    wr(12'h14C, 32'h0000_1003);
    rd(12'h14C, v); chk("R8 ptr write", v, 32'h0000_1000);
    rd(12'h10C, v); chk("R8 base kept", v, 32'h1234_5678);
  endtask

  task automatic t_gstop();
    logic [31:0] v;
    wr(12'h008, 32'h6);
    rd(12'h000, v); chk("R9 gts idle", v, 32'h0000_0002);
    chk("R9 tx_stop", {31'd0, tx_stop}, 1);
    wr(12'h000, 32'hFFFF_FFFF);
    rx_busy = 1'b1; step();
    wr(12'h008, 32'h5);
    rd(12'h000, v); chk("R10 deferred", v, 0);
    step(); step();
    rd(12'h000, v); chk("R10 still busy", v, 0);
    rx_busy = 1'b0; #1;
    rd(12'h000, v); chk("R10 not yet", v, 0);
    step();
    rd(12'h000, v); chk("R10 after frame", v, 32'h0000_0200);
    wr(12'h000, 32'hFFFF_FFFF);
  endtask

  task automatic t_poll();
    int first;
    wr(12'h008, 32'h0);
    chk("R11 no early", {24'd0, tx_rs}, 0);
    first = 0;
    for (int n = 1; n <= 2*P + 1; n++) begin
      step();
      chk("R11 poll", {31'd0, tx_rs[0]}, (n == P || n == 2*P) ? 1 : 0);
    end
    wr(12'h008, 32'h2);
    for (int n = 1; n <= 2*P; n++) begin
      step();
      if (tx_rs[0]) first++;
    end
    chk("R11 gts gates", first, 0);
    wr(12'h008, 32'h4);
    first = 0;
    for (int n = 1; n <= 2*P; n++) begin
      step();
      if (tx_rs[0]) first++;
    end
    chk("R11 wop holds", first, 0);
  endtask

  initial begin
    #1600000;
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_access();
    t_events();
    t_tx_halt();
    t_rx_halt();
    t_ring();
    t_gstop();
    t_poll();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule